// File: doc/BRIEF.md
# Microcontroller Privilege Mode Controller

This block decides which privilege level an embedded microcontroller core runs at: non-secure, light-secure or heavy-secure. The host loads code by writing two control registers. One marks an instruction-memory block as secure. The other holds the signature word. The host then pulses a start strobe. If both registers were written in that order, the controller asks an external signature checker for a verdict and waits in a pending state. A passing result grants heavy-secure. A failing result leaves the core non-secure.

Secure code that is already running may ask for light-secure. A request that arrives from the host register port is ignored. From the moment a secure start is accepted, the controller blocks instruction-memory writes that fall in the tagged block. A halt strobe or a reset ends the protection and clears the loaded state.

Top module: `ucsec_mode_ctrl`

## Requirements
- R1: `mode` reports 2'b00 for non-secure, 2'b01 for light-secure and 2'b10 for heavy-secure, and never 2'b11. After reset `mode`=00 and `pending`, `wp_en`, `chk_start` and `imem_we` are all 0, and no tag or signature is held.
- R2: A host write to offset 4'h0 tags a block, with the block index taken from `host_wr_data[BLK_AW-1:0]`; re-tagging drops any held signature. A host write to offset 4'h4 stores the signature, and is recorded only if a tag is already held.
- R3: A start in non-secure mode while both tag and signature are held enters pending. On the next cycle `mode`=00, `pending`=1 and `wp_en`=1, and `chk_start` is high for exactly that one cycle.
- R4: A start in non-secure mode without both tag and signature held leaves `mode`=00 and `wp_en`=0, and clears any tag or signature. A later start therefore needs a fresh tag and signature.
- R5: In pending, `chk_valid`=1 with `chk_pass`=1 gives `mode`=10 on the next cycle. `chk_valid`=1 with `chk_pass`=0 gives `mode`=00 with `wp_en`=0 and clears tag and signature. Without `chk_valid` the state stays pending indefinitely. `chk_valid` outside pending has no effect.
- R6: `core_ls_req` in heavy-secure gives `mode`=01 on the next cycle. It has no effect in any other mode. A host write to offset 4'h8, the host-side light-secure request, never changes the mode.
- R7: While pending, heavy-secure or light-secure, host writes to the tag and signature offsets are ignored, and so is a start strobe.
- R8: `halt` in any mode gives `mode`=00, `pending`=0 and `wp_en`=0 on the next cycle, and clears tag and signature. It takes priority over every other input in the same cycle.
- R9: The block of an instruction-memory address is `imem_wr_addr[IMEM_AW-1 -: BLK_AW]`. While `wp_en`=1, a write to the tagged block gives `imem_we`=0 on the next cycle. Every other write appears one cycle later on `imem_we`/`imem_waddr`/`imem_wdata`.
- R10: `chk_sig` and `chk_blk` present the held signature and tagged block index to the checker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | ADDR_W | Host register offset |
| host_wr_data | input | DATA_W | Host write data |
| start | input | 1 | Start-execution strobe |
| halt | input | 1 | Execution halted |
| core_ls_req | input | 1 | Light-secure request from running code |
| chk_valid | input | 1 | Checker result valid |
| chk_pass | input | 1 | Checker verdict, 1 = signature good |
| chk_start | output | 1 | One-cycle request to the checker |
| chk_sig | output | DATA_W | Held signature word |
| chk_blk | output | BLK_AW | Tagged block index |
| mode | output | 2 | Current privilege mode |
| pending | output | 1 | Awaiting checker verdict |
| wp_en | output | 1 | Code region write protect active |
| imem_wr_en | input | 1 | Instruction memory write request |
| imem_wr_addr | input | IMEM_AW | Instruction memory write address |
| imem_wr_data | input | IMEM_DW | Instruction memory write data |
| imem_we | output | 1 | Filtered write enable |
| imem_waddr | output | IMEM_AW | Registered write address |
| imem_wdata | output | IMEM_DW | Registered write data |

## Verification
The hardest state to reach from the ports is light-secure with a protected block whose tag the host has tried to overwrite. Getting there takes a correct tag-then-signature order, an accepted start, a passing verdict and a request from the core, in that sequence. The bench builds this state step by step through the vector table and the directed tests. It then aims instruction-memory writes at the old block and at the new block, so it can see whether the ignored re-tag leaked into the protect logic. Out-of-order loads, stray checker results and a halt that arrives together with a light-secure request cover the remaining edges of the state machine.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {MODE_NS = 2'b00, MODE_LS = 2'b01, MODE_HS = 2'b10} mode_e;
  typedef enum logic [1:0] {ST_NS, ST_PEND, ST_HS, ST_LS} st_e;

  localparam int OFF_TAG   = 0;
  localparam int OFF_SIG   = 4;
  localparam int OFF_LSREQ = 8;

  function automatic logic [1:0] st2mode(st_e s);
    case (s)
      ST_HS:   return MODE_HS;
      ST_LS:   return MODE_LS;
      default: return MODE_NS;
    endcase
  endfunction
endpackage

// File: rtl/smc_load_track.sv
module smc_load_track #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int BLK_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock,
  input  logic              clr,
  output logic              tag_vld,
  output logic              sig_vld,
  output logic [BLK_AW-1:0] tag_blk,
  output logic [DATA_W-1:0] sig_word
);
  import smc_pkg::*;

  logic hit_tag, hit_sig;
  assign hit_tag = wr_en && !lock && (wr_addr == ADDR_W'(OFF_TAG));
  assign hit_sig = wr_en && !lock && (wr_addr == ADDR_W'(OFF_SIG));

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_vld  <= 1'b0;
      sig_vld  <= 1'b0;
      tag_blk  <= '0;
      sig_word <= '0;
    end else if (clr) begin
      tag_vld <= 1'b0;
      sig_vld <= 1'b0;
    end else begin
      if (hit_tag) begin
        tag_vld <= 1'b1;
        sig_vld <= 1'b0;
        tag_blk <= wr_data[BLK_AW-1:0];
      end else if (hit_sig && tag_vld) begin
        sig_vld  <= 1'b1;
        sig_word <= wr_data;
      end
    end
  end

  // R2: a signature only becomes valid on top of an existing tag
  assert_sig_order_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_vld) |-> $past(tag_vld));

  // R7: locked writes leave the held tag and signature alone
  assert_locked_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lock && !clr) |=> ($stable(tag_blk) && $stable(sig_word)));
endmodule

// File: rtl/smc_mode_fsm.sv
module smc_mode_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       halt,
  input  logic       chk_valid,
  input  logic       chk_pass,
  input  logic       ls_req,
  input  logic       tag_vld,
  input  logic       sig_vld,
  output logic [1:0] mode,
  output logic       pending,
  output logic       wp_en,
  output logic       chk_start,
  output logic       lock,
  output logic       seq_clr
);
  import smc_pkg::*;

  st_e  state_q, state_d;
  logic armed;

  assign armed = tag_vld && sig_vld;
  assign lock  = (state_q != ST_NS);

  always_comb begin
    state_d = state_q;
    seq_clr = 1'b0;
    if (halt) begin
      state_d = ST_NS;
      seq_clr = 1'b1;
    end else begin
      case (state_q)
        ST_NS: if (start) begin
          if (armed) state_d = ST_PEND;
          else       seq_clr = 1'b1;
        end
        ST_PEND: if (chk_valid) begin
          if (chk_pass) state_d = ST_HS;
          else begin
            state_d = ST_NS;
            seq_clr = 1'b1;
          end
        end
        ST_HS: if (ls_req) state_d = ST_LS;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_NS;
      mode      <= MODE_NS;
      pending   <= 1'b0;
      wp_en     <= 1'b0;
      chk_start <= 1'b0;
    end else begin
      state_q   <= state_d;
      mode      <= st2mode(state_d);
      pending   <= (state_d == ST_PEND);
      wp_en     <= (state_d != ST_NS);
      chk_start <= (state_q == ST_NS) && (state_d == ST_PEND);
    end
  end

  // R1: the unused encoding never appears
  always_comb assert_mode_legal_R1: assert (rst || mode != 2'b11);

  // R3: pending is entered only from an armed start
  assert_pend_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND && $past(state_q) != ST_PEND) |-> $past(start && tag_vld && sig_vld));

  // R3: checker request is a single-cycle pulse
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    chk_start |=> !chk_start);

  // R5: heavy-secure only after a passing verdict
  assert_hs_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HS && $past(state_q) != ST_HS) |-> $past(chk_valid && chk_pass && state_q == ST_PEND));

  // R6: light-secure only out of heavy-secure
  assert_ls_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LS && $past(state_q) != ST_LS) |-> $past(state_q == ST_HS && ls_req));

  // R8: halt returns to non-secure and drops protection
  assert_halt_ns_R8: assert property (@(posedge clk) disable iff (rst)
    halt |=> (mode == MODE_NS && !wp_en && !pending));
endmodule

// File: rtl/smc_wp_gate.sv
module smc_wp_gate #(
  parameter int IMEM_AW = 12,
  parameter int IMEM_DW = 32,
  parameter int BLK_AW  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wp_en,
  input  logic [BLK_AW-1:0]  prot_blk,
  input  logic               wr_en,
  input  logic [IMEM_AW-1:0] wr_addr,
  input  logic [IMEM_DW-1:0] wr_data,
  output logic               we_o,
  output logic [IMEM_AW-1:0] waddr_o,
  output logic [IMEM_DW-1:0] wdata_o
);
  localparam int BLK_LSB = IMEM_AW - BLK_AW;

  logic blk_hit;
  assign blk_hit = (wr_addr[IMEM_AW-1:BLK_LSB] == prot_blk);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o    <= wr_en && !(wp_en && blk_hit);
      waddr_o <= wr_addr;
      wdata_o <= wr_data;
    end
  end

  // R9: protected block writes are dropped
  assert_wp_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (wp_en && wr_en && wr_addr[IMEM_AW-1 -: BLK_AW] == prot_blk) |=> !we_o);

  // R9: with no protection every write passes
  assert_wp_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wp_en) |=> (we_o && waddr_o == $past(wr_addr)));
endmodule

// File: rtl/ucsec_mode_ctrl.sv
module ucsec_mode_ctrl #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int BLK_AW  = 4,
  parameter int IMEM_AW = 12,
  parameter int IMEM_DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr_en,
  input  logic [ADDR_W-1:0]  host_wr_addr,
  input  logic [DATA_W-1:0]  host_wr_data,
  input  logic               start,
  input  logic               halt,
  input  logic               core_ls_req,
  input  logic               chk_valid,
  input  logic               chk_pass,
  output logic               chk_start,
  output logic [DATA_W-1:0]  chk_sig,
  output logic [BLK_AW-1:0]  chk_blk,
  output logic [1:0]         mode,
  output logic               pending,
  output logic               wp_en,
  input  logic               imem_wr_en,
  input  logic [IMEM_AW-1:0] imem_wr_addr,
  input  logic [IMEM_DW-1:0] imem_wr_data,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_waddr,
  output logic [IMEM_DW-1:0] imem_wdata
);
  logic tag_vld, sig_vld, lock, seq_clr;

  smc_load_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_AW(BLK_AW)) u_track (
    .clk(clk), .rst(rst),
    .wr_en(host_wr_en), .wr_addr(host_wr_addr), .wr_data(host_wr_data),
    .lock(lock), .clr(seq_clr),
    .tag_vld(tag_vld), .sig_vld(sig_vld), .tag_blk(chk_blk), .sig_word(chk_sig)
  );

  smc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .halt(halt),
    .chk_valid(chk_valid), .chk_pass(chk_pass), .ls_req(core_ls_req),
    .tag_vld(tag_vld), .sig_vld(sig_vld),
    .mode(mode), .pending(pending), .wp_en(wp_en), .chk_start(chk_start),
    .lock(lock), .seq_clr(seq_clr)
  );

  smc_wp_gate #(.IMEM_AW(IMEM_AW), .IMEM_DW(IMEM_DW), .BLK_AW(BLK_AW)) u_gate (
    .clk(clk), .rst(rst), .wp_en(wp_en), .prot_blk(chk_blk),
    .wr_en(imem_wr_en), .wr_addr(imem_wr_addr), .wr_data(imem_wr_data),
    .we_o(imem_we), .waddr_o(imem_waddr), .wdata_o(imem_wdata)
  );
endmodule

// File: tb/sim_ucsec_mode_ctrl.sv
`timescale 1ns/1ps
module sim_ucsec_mode_ctrl;
  logic        clk = 0, rst = 1;
  logic        host_wr_en = 0;
  logic [3:0]  host_wr_addr = 0;
  logic [31:0] host_wr_data = 0;
  logic        start = 0, halt = 0, core_ls_req = 0, chk_valid = 0, chk_pass = 0;
  logic        chk_start, pending, wp_en, imem_we;
  logic [31:0] chk_sig, imem_wdata;
  logic [3:0]  chk_blk;
  logic [1:0]  mode;
  logic        imem_wr_en = 0;
  logic [11:0] imem_wr_addr = 0, imem_waddr;
  logic [31:0] imem_wr_data = 0;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ucsec_mode_ctrl u0 (.*);

  localparam logic [3:0] OP_IDLE = 0, OP_TAG = 1, OP_SIG = 2, OP_START = 3, OP_PASS = 4,
                         OP_FAIL = 5, OP_LSC = 6, OP_LSH = 7, OP_HALT = 8;
  // {op, arg, req, mode, pending, wp}
  localparam int NV = 28;
  localparam logic [15:0] VEC [0:NV-1] = '{
    {OP_IDLE,  4'd0, 4'd1, 2'b00, 1'b0, 1'b0},  // R1
    {OP_START, 4'd0, 4'd4, 2'b00, 1'b0, 1'b0},  // R4 bare start
    {OP_SIG,   4'd0, 4'd2, 2'b00, 1'b0, 1'b0},  // R2 sig without tag
    {OP_TAG,   4'd2, 4'd2, 2'b00, 1'b0, 1'b0},
    {OP_START, 4'd0, 4'd4, 2'b00, 1'b0, 1'b0},  // R4 tag only
    {OP_TAG,   4'd1, 4'd2, 2'b00, 1'b0, 1'b0},
    {OP_SIG,   4'd0, 4'd2, 2'b00, 1'b0, 1'b0},
    {OP_START, 4'd0, 4'd3, 2'b00, 1'b1, 1'b1},  // R3
    {OP_IDLE,  4'd0, 4'd5, 2'b00, 1'b1, 1'b1},  // R5 hold
    {OP_FAIL,  4'd0, 4'd5, 2'b00, 1'b0, 1'b0},  // R5 fail
    {OP_TAG,   4'd1, 4'd2, 2'b00, 1'b0, 1'b0},
    {OP_SIG,   4'd0, 4'd2, 2'b00, 1'b0, 1'b0},
    {OP_START, 4'd0, 4'd3, 2'b00, 1'b1, 1'b1},
    {OP_LSC,   4'd0, 4'd6, 2'b00, 1'b1, 1'b1},  // R6 ignored in pending
    {OP_PASS,  4'd0, 4'd5, 2'b10, 1'b0, 1'b1},  // R5 pass
    {OP_LSH,   4'd0, 4'd6, 2'b10, 1'b0, 1'b1},  // R6 host request
    {OP_TAG,   4'd3, 4'd7, 2'b10, 1'b0, 1'b1},  // R7
    {OP_START, 4'd0, 4'd7, 2'b10, 1'b0, 1'b1},  // R7
    {OP_LSC,   4'd0, 4'd6, 2'b01, 1'b0, 1'b1},  // R6
    {OP_LSC,   4'd0, 4'd6, 2'b01, 1'b0, 1'b1},
    {OP_PASS,  4'd0, 4'd5, 2'b01, 1'b0, 1'b1},  // R5 stray verdict
    {OP_HALT,  4'd0, 4'd8, 2'b00, 1'b0, 1'b0},  // R8
    {OP_START, 4'd0, 4'd8, 2'b00, 1'b0, 1'b0},  // R8 cleared
    {OP_SIG,   4'd0, 4'd2, 2'b00, 1'b0, 1'b0},
    {OP_TAG,   4'd0, 4'd2, 2'b00, 1'b0, 1'b0},
    {OP_START, 4'd0, 4'd2, 2'b00, 1'b0, 1'b0},  // R2 wrong order
    {OP_LSC,   4'd0, 4'd6, 2'b00, 1'b0, 1'b0},  // R6 in NS
    {OP_PASS,  4'd0, 4'd5, 2'b00, 1'b0, 1'b0}   // R5 verdict in NS
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    host_wr_en = 0; start = 0; halt = 0; core_ls_req = 0;
    chk_valid = 0; chk_pass = 0; imem_wr_en = 0;
  endtask

  task automatic do_op(logic [3:0] op, logic [3:0] arg, logic [31:0] sig);
    case (op)
      OP_TAG:   begin host_wr_en = 1; host_wr_addr = 4'h0; host_wr_data = {28'h0, arg}; end
      OP_SIG:   begin host_wr_en = 1; host_wr_addr = 4'h4; host_wr_data = sig; end
      OP_LSH:   begin host_wr_en = 1; host_wr_addr = 4'h8; host_wr_data = 32'h1; end
      OP_START: start = 1;
      OP_PASS:  begin chk_valid = 1; chk_pass = 1; end
      OP_FAIL:  begin chk_valid = 1; chk_pass = 0; end
      OP_LSC:   core_ls_req = 1;
      OP_HALT:  halt = 1;
      default:  ;
    endcase
    step();
  endtask

  task automatic imem_wr(logic [11:0] a, logic [31:0] d);
    imem_wr_en = 1; imem_wr_addr = a; imem_wr_data = d;
    step();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 pending", pending, 0);
    chk("R1 wp", wp_en, 0);
    chk("R1 chk_start", chk_start, 0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      do_op(v[15:12], v[11:8], 32'hC0DE0000 + i);
      chk($sformatf("R%0d vec%0d mode", v[7:4], i), mode, v[3:2]);
      chk($sformatf("R%0d vec%0d pending", v[7:4], i), pending, v[1]);
      chk($sformatf("R%0d vec%0d wp", v[7:4], i), wp_en, v[0]);
      chk($sformatf("R3 vec%0d chk_start", i), chk_start, (v[15:12] == OP_START) && v[1]);
    end

    // R8 halt wins over a same-cycle light-secure request
    do_op(OP_TAG, 4'd1, 0); do_op(OP_SIG, 0, 32'h1111); do_op(OP_START, 0, 0); do_op(OP_PASS, 0, 0);
    chk("R5 mode hs", mode, 2'b10);
    halt = 1; core_ls_req = 1; step();
    chk("R8 priority mode", mode, 2'b00);
    chk("R8 priority wp", wp_en, 0);

    // R10 / R9 / R7 write protect and ignored re-tag
    do_op(OP_TAG, 4'd1, 0); do_op(OP_SIG, 0, 32'hA5A5_5A5A); do_op(OP_START, 0, 0);
    chk("R10 chk_sig", chk_sig, 32'hA5A5_5A5A);
    chk("R10 chk_blk", chk_blk, 1);
    imem_wr(12'h140, 32'h77);
    chk("R9 pending block drop", imem_we, 0);
    do_op(OP_PASS, 0, 0);
    do_op(OP_TAG, 4'd3, 0);
    chk("R7 tag held", chk_blk, 1);
    imem_wr(12'h1F0, 32'h5);
    chk("R9 tagged block drop", imem_we, 0);
    imem_wr(12'h310, 32'hBEEF);
    chk("R9 other block pass", imem_we, 1);
    chk("R9 addr", imem_waddr, 12'h310);
    chk("R9 data", imem_wdata, 32'hBEEF);
    do_op(OP_LSC, 0, 0);
    chk("R6 ls", mode, 2'b01);
    imem_wr(12'h100, 32'h9);
    chk("R9 drop in ls", imem_we, 0);
    do_op(OP_HALT, 0, 0);
    imem_wr(12'h100, 32'h9);
    chk("R9 pass after halt", imem_we, 1);

    // R5 pending held without a verdict
    do_op(OP_TAG, 4'd2, 0); do_op(OP_SIG, 0, 32'h2); do_op(OP_START, 0, 0);
    repeat (20) step();
    chk("R5 long pending", pending, 1);
    chk("R5 long pending mode", mode, 0);
    do_op(OP_PASS, 0, 0);
    do_op(OP_LSC, 0, 0);
    chk("R6 ls before reset", mode, 2'b01);

    // R1 reset from light-secure, R4 reset cleared the load
    rst = 1; step(); rst = 0;
    chk("R1 reset mode", mode, 0);
    chk("R1 reset wp", wp_en, 0);
    do_op(OP_START, 0, 0);
    chk("R4 start after reset", pending, 0);
    chk("R4 start after reset mode", mode, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule